// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop is in lock by timing the rising-edge pulses that reach its phase-frequency detector. Each pulse input is one cycle wide and is synchronous to a fast sampling clock. Whichever pulse arrives first starts an interval timer. The partner pulse stops it, and the elapsed tick count becomes one comparison cycle. A result below the lock window counts toward lock. The flag is raised only after a run of such results, with a run length chosen by a 2-bit code.

Once the flag is up it has hysteresis. Results between the lock window and a wider loss threshold leave it set. Only an interval beyond the loss threshold clears it. A missing partner pulse is also treated as beyond the threshold. A range select picks one of two window/threshold pairs. A disable input forces the detector into a cleared, unlocked state.

The edge strobes and configuration pins are plain level or pulse signals. There is no data stream, and so there is no handshake or back-pressure.

Top module: `digital_lock_detector`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `locked` is 0.
- R2: `cnt_sel` selects the number of consecutive in-window comparison cycles needed for lock: 00 = 5, 01 = 16, 10 = 64, 11 = 255. `locked` rises on the clock edge that samples the partner pulse completing the qualifying comparison.
- R3: A comparison's difference is the number of clock cycles from the first pulse to the partner pulse. Pulses in the same cycle give 0. The comparison is in-window when the difference is strictly less than the lock window.
- R4: While unlocked, any comparison that is not in-window clears the consecutive count to zero.
- R5: While locked, a difference up to and including the loss threshold keeps `locked` at 1. A larger difference clears `locked` and the count on that edge.
- R6: If no partner pulse arrives within loss threshold + 1 cycles of the first pulse, the comparison ends at that cycle and is treated as beyond the loss threshold.
- R7: While `det_off` is 1, `locked` is forced to 0, the count is held at zero, and any running measurement is abandoned.
- R8: `range_low` = 0 selects a lock window of 8 ticks and a loss threshold of 16 ticks. `range_low` = 1 selects 4 and 8 ticks.
- R9: A repeat of the first pulse's own kind while the timer is waiting for the partner is ignored and does not restart the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 1 | One-cycle pulse marking a reference rising edge |
| fb_edge | input | 1 | One-cycle pulse marking a feedback rising edge |
| cnt_sel | input | 2 | Consecutive-cycle count code |
| range_low | input | 1 | Window range select (0 high, 1 low) |
| det_off | input | 1 | Disable lock detection |
| locked | output | 1 | Lock flag |

## Verification
The bench targets the exact window edges: a difference of window−1 must count and a difference equal to the window must not. A design using `<=` would lock one comparison cycle early in that pattern. Hysteresis is exercised at the loss threshold and one tick above it. A design that compared against the lock window after lock would drop the flag while still near lock. Timeouts are probed for the precise cycle of flag loss, and so is a repeated first pulse that a timer restart would turn into a falsely short interval. Disable pulses in the middle of a run check that a stale partial count cannot cut a later run short.

// File: rtl/dld_pkg.sv
package dld_pkg;

  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_WAIT = 1'b1
  } meas_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/window_select.sv
module window_select
  import dld_pkg::*;
#(
  parameter int unsigned WIN_HI  = 8,
  parameter int unsigned LOSS_HI = 16,
  parameter int unsigned WIN_LO  = 4,
  parameter int unsigned LOSS_LO = 8,
  parameter int unsigned TW      = 5
) (
  input  logic          range_low,
  output logic [TW-1:0] win,
  output logic [TW-1:0] thr,
  output logic [TW-1:0] limit
);

  localparam logic [TW-1:0] WIN_HI_V  = TW'(WIN_HI);
  localparam logic [TW-1:0] LOSS_HI_V = TW'(LOSS_HI);
  localparam logic [TW-1:0] WIN_LO_V  = TW'(WIN_LO);
  localparam logic [TW-1:0] LOSS_LO_V = TW'(LOSS_LO);

  always_comb begin
    if (range_low) begin
      win = WIN_LO_V;
      thr = LOSS_LO_V;
    end else begin
      win = WIN_HI_V;
      thr = LOSS_HI_V;
    end
    limit = thr + 1'b1;
  end

endmodule

// File: rtl/edge_interval_timer.sv
module edge_interval_timer
  import dld_pkg::*;
#(
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ref_pls,
  input  logic          fb_pls,
  input  logic [TW-1:0] limit,
  output logic          done,
  output logic [TW-1:0] diff,
  output logic          timed_out
);

  meas_state_e   state;
  logic          first_ref;
  logic [TW-1:0] timer;
  logic          partner;

  always_comb begin
    done      = 1'b0;
    diff      = '0;
    timed_out = 1'b0;
    partner   = first_ref ? fb_pls : ref_pls;
    if (!clr) begin
      if (state == MS_IDLE) begin
        if (ref_pls && fb_pls) begin
          done = 1'b1;
        end
      end else begin
        if (partner) begin
          done = 1'b1;
          diff = timer;
        end else if (timer >= limit) begin
          done      = 1'b1;
          diff      = timer;
          timed_out = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= MS_IDLE;
      first_ref <= 1'b0;
      timer     <= '0;
    end else if (clr) begin
      state     <= MS_IDLE;
      first_ref <= 1'b0;
      timer     <= '0;
    end else if (state == MS_IDLE) begin
      if (ref_pls ^ fb_pls) begin
        state     <= MS_WAIT;
        first_ref <= ref_pls;
        timer     <= TW'(1);
      end
    end else begin
      if (done) begin
        state <= MS_IDLE;
        timer <= '0;
      end else begin
        timer <= timer + 1'b1;
      end
    end
  end

  AST_WAIT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_IDLE && (ref_pls ^ fb_pls) && !clr) |=> (state == MS_WAIT && timer == TW'(1))) // R3
    else $error("measurement did not start");

  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_WAIT && done) |=> (state == MS_IDLE)) // R6
    else $error("measurement did not end");

  AST_REPEAT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_WAIT && !done && !clr) |=> (state == MS_WAIT && timer == $past(timer) + 1'b1)) // R9
    else $error("timer disturbed while waiting");

endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import dld_pkg::*;
#(
  parameter int unsigned TW   = 5,
  parameter int unsigned TGT0 = 5,
  parameter int unsigned TGT1 = 16,
  parameter int unsigned TGT2 = 64,
  parameter int unsigned TGT3 = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_off,
  input  logic [1:0]    cnt_sel,
  input  logic          res_valid,
  input  logic [TW-1:0] res_diff,
  input  logic          res_tout,
  input  logic [TW-1:0] win,
  input  logic [TW-1:0] thr,
  output logic          lock
);

  localparam int unsigned TMAX = max2(max2(TGT0, TGT1), max2(TGT2, TGT3));
  localparam int unsigned CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] target;
  logic          res_in;
  logic          res_far;

  always_comb begin
    unique case (cnt_sel)
      2'b00:   target = CW'(TGT0);
      2'b01:   target = CW'(TGT1);
      2'b10:   target = CW'(TGT2);
      default: target = CW'(TGT3);
    endcase
    res_in  = !res_tout && (res_diff < win);
    res_far = res_tout || (res_diff > thr);
    cnt_inc = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      lock <= 1'b0;
    end else if (det_off) begin
      cnt  <= '0;
      lock <= 1'b0;
    end else if (res_valid) begin
      if (lock) begin
        if (res_far) begin
          lock <= 1'b0;
          cnt  <= '0;
        end
      end else if (res_in) begin
        if (cnt_inc >= target) begin
          lock <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt_inc;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    det_off |=> (!lock && cnt == '0)) // R7
    else $error("disable did not clear");

  AST_MISS_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_in && !lock) |=> (cnt == '0)) // R4
    else $error("miss did not clear count");

  AST_HOLD_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && res_valid && !res_far && !det_off) |=> lock) // R5
    else $error("lock lost inside threshold");

  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(res_valid && res_in)) // R2
    else $error("lock rose without in-window result");

  AST_LOCKED_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (cnt == '0)) // R2
    else $error("count nonzero while locked");

endmodule

// File: rtl/digital_lock_detector.sv
module digital_lock_detector
  import dld_pkg::*;
#(
  parameter int unsigned WIN_HI  = 8,
  parameter int unsigned LOSS_HI = 16,
  parameter int unsigned WIN_LO  = 4,
  parameter int unsigned LOSS_LO = 8,
  parameter int unsigned TGT0    = 5,
  parameter int unsigned TGT1    = 16,
  parameter int unsigned TGT2    = 64,
  parameter int unsigned TGT3    = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_edge,
  input  logic       fb_edge,
  input  logic [1:0] cnt_sel,
  input  logic       range_low,
  input  logic       det_off,
  output logic       locked
);

  localparam int unsigned TW = $clog2(max2(LOSS_HI, LOSS_LO) + 2);

  logic [TW-1:0] win;
  logic [TW-1:0] thr;
  logic [TW-1:0] limit;
  logic          res_valid;
  logic [TW-1:0] res_diff;
  logic          res_tout;

  window_select #(
    .WIN_HI(WIN_HI), .LOSS_HI(LOSS_HI), .WIN_LO(WIN_LO), .LOSS_LO(LOSS_LO), .TW(TW)
  ) u_win (
    .range_low(range_low),
    .win      (win),
    .thr      (thr),
    .limit    (limit)
  );

  edge_interval_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (det_off),
    .ref_pls  (ref_edge),
    .fb_pls   (fb_edge),
    .limit    (limit),
    .done     (res_valid),
    .diff     (res_diff),
    .timed_out(res_tout)
  );

  lock_qualifier #(
    .TW(TW), .TGT0(TGT0), .TGT1(TGT1), .TGT2(TGT2), .TGT3(TGT3)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_off  (det_off),
    .cnt_sel  (cnt_sel),
    .res_valid(res_valid),
    .res_diff (res_diff),
    .res_tout (res_tout),
    .win      (win),
    .thr      (thr),
    .lock     (locked)
  );

  AST_RESET_UNLOCKED: assert property (@(posedge clk)
    !rst_n |=> !locked) // R1
    else $error("locked right after reset");

endmodule

// File: tb/digital_lock_detector_test.sv
module digital_lock_detector_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_edge = 1'b0;
  logic       fb_edge = 1'b0;
  logic [1:0] cnt_sel = 2'b00;
  logic       range_low = 1'b0;
  logic       det_off = 1'b0;
  logic       locked;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit started = 0;

  // reference model state
  bit m_lock = 0;
  int m_cnt = 0;
  bit m_wait = 0;
  bit m_first_ref = 0;
  int m_age = 0;

  always #2 clk = ~clk;

  digital_lock_detector uut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .cnt_sel(cnt_sel), .range_low(range_low), .det_off(det_off), .locked(locked)
  );

  function automatic int tgt(input logic [1:0] s);
    case (s)
      2'b00: return 5;
      2'b01: return 16;
      2'b10: return 64;
      default: return 255;
    endcase
  endfunction

  always @(posedge clk) begin
    int lw, lt, d;
    bit got, partner;
    started <= 1'b1;
    if (!rst_n || det_off) begin
      m_lock = 0; m_cnt = 0; m_wait = 0; m_age = 0;
    end else begin
      lw = range_low ? 4 : 8;
      lt = range_low ? 8 : 16;
      got = 0; d = 0;
      if (!m_wait) begin
        if (ref_edge && fb_edge) begin got = 1; d = 0; end
        else if (ref_edge || fb_edge) begin m_wait = 1; m_first_ref = ref_edge; m_age = 0; end
      end else begin
        m_age++;
        partner = m_first_ref ? fb_edge : ref_edge;
        if (partner || m_age >= lt + 1) begin got = 1; d = m_age; m_wait = 0; end
      end
      if (got) begin
        if (m_lock) begin
          if (d > lt) begin m_lock = 0; m_cnt = 0; end
        end else if (d < lw) begin
          if (m_cnt + 1 >= tgt(cnt_sel)) begin m_lock = 1; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      compared++;
      if (locked !== m_lock) begin
        mismatched++;
        $display("FAIL %s per-clock: locked actual=%b expected=%b at %0t", cur_req, locked, m_lock, $time);
      end
    end
  end

  task automatic check(input logic exp, input string req, input string what);
    compared++;
    if (locked !== exp) begin
      mismatched++;
      $display("FAIL %s %s: locked actual=%b expected=%b", req, what, locked, exp);
    end
  endtask

  task automatic send_pair(input bit ref_first, input int d, input int gap);
    @(negedge clk);
    if (d == 0) begin ref_edge = 1; fb_edge = 1; end
    else if (ref_first) ref_edge = 1; else fb_edge = 1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      ref_edge = 0; fb_edge = 0;
    end
    if (d > 0) begin
      if (ref_first) fb_edge = 1; else ref_edge = 1;
    end
    @(negedge clk);
    ref_edge = 0; fb_edge = 0;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic reconf(input logic [1:0] s, input logic rl);
    @(negedge clk);
    det_off = 1;
    @(negedge clk);
    cnt_sel = s; range_low = rl;
    @(negedge clk);
    det_off = 0;
  endtask

  task automatic run_pairs(input int n, input int d);
    for (int i = 0; i < n; i++) send_pair(i[0], d, 0);
  endtask

  initial begin
    #(4 * 150000);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check(1'b0, "R1", "during reset");
    rst_n = 1;
    @(negedge clk);
    check(1'b0, "R1", "after reset");

    // R2 R3 five in-window cycles (high range, d=7 < 8)
    cur_req = "R2";
    run_pairs(4, 7);
    check(1'b0, "R2", "after 4 of 5");
    send_pair(1, 7, 0);
    check(1'b1, "R2", "after 5 of 5");

    // R5 hysteresis at threshold
    cur_req = "R5";
    send_pair(1, 12, 1);
    check(1'b1, "R5", "diff 12 keeps lock");
    send_pair(0, 16, 1);
    check(1'b1, "R5", "diff 16 keeps lock");
    send_pair(1, 17, 1);
    check(1'b0, "R5", "diff 17 drops lock");

    // R3 R4 window edge: 8 is not in-window
    cur_req = "R4";
    run_pairs(4, 2);
    send_pair(1, 8, 0);
    check(1'b0, "R3", "diff 8 not counted");
    run_pairs(4, 0);
    check(1'b0, "R4", "count restarted after miss");
    send_pair(0, 1, 0);
    check(1'b1, "R4", "lock after 5 fresh");

    // R6 timeout: ref with no partner, high range loss 16
    cur_req = "R6";
    @(negedge clk);
    ref_edge = 1;
    @(negedge clk);
    ref_edge = 0;
    repeat (16) @(negedge clk);
    check(1'b1, "R6", "before timeout");
    @(negedge clk);
    check(1'b0, "R6", "timeout drops lock");
    repeat (3) @(negedge clk);

    // R8 low range: window 4, threshold 8
    cur_req = "R8";
    reconf(2'b00, 1'b1);
    run_pairs(4, 3);
    send_pair(1, 4, 0);
    check(1'b0, "R8", "diff 4 out in low range");
    run_pairs(5, 3);
    check(1'b1, "R8", "lock in low range");
    send_pair(1, 8, 1);
    check(1'b1, "R8", "diff 8 keeps lock");
    send_pair(0, 9, 1);
    check(1'b0, "R8", "diff 9 drops lock");

    // R9 repeated first edge ignored (low range, window 4)
    cur_req = "R9";
    run_pairs(4, 1);
    @(negedge clk); ref_edge = 1;
    @(negedge clk); ref_edge = 0;
    @(negedge clk); ref_edge = 1;
    @(negedge clk); ref_edge = 0;
    @(negedge clk);
    @(negedge clk); fb_edge = 1;
    @(negedge clk); fb_edge = 0;
    check(1'b0, "R9", "repeat did not restart timer");
    repeat (2) @(negedge clk);

    // R7 disable mid-run and while locked
    cur_req = "R7";
    reconf(2'b00, 1'b0);
    run_pairs(4, 2);
    @(negedge clk); det_off = 1;
    @(negedge clk); det_off = 0;
    run_pairs(4, 2);
    check(1'b0, "R7", "count cleared by disable");
    send_pair(1, 2, 0);
    check(1'b1, "R7", "lock after full run");
    @(negedge clk); det_off = 1;
    @(negedge clk);
    check(1'b0, "R7", "disable forces low");
    run_pairs(5, 2);
    check(1'b0, "R7", "no lock while disabled");
    det_off = 0;
    @(negedge clk);

    // R2 other count codes
    cur_req = "R2";
    reconf(2'b01, 1'b0);
    run_pairs(15, 5);
    check(1'b0, "R2", "15 of 16");
    send_pair(1, 5, 0);
    check(1'b1, "R2", "16 of 16");
    reconf(2'b10, 1'b0);
    run_pairs(63, 4);
    check(1'b0, "R2", "63 of 64");
    send_pair(0, 4, 0);
    check(1'b1, "R2", "64 of 64");
    reconf(2'b11, 1'b0);
    run_pairs(254, 0);
    check(1'b0, "R2", "254 of 255");
    send_pair(1, 6, 0);
    check(1'b1, "R2", "255 of 255");

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule